// File: doc/BRIEF.md
# Partial-Width Load/Store Lane Aligner

This block is the memory-side data path for byte, halfword and word accesses to a 32-bit wide, word-indexed data memory. From a base register value and a 16-bit displacement it forms the byte address. For a store it builds per-byte write enables and replicates the source value into the right lanes. For a load it picks the addressed byte or halfword out of the stored word and widens it to 32 bits, with sign or zero fill as the opcode asks. A small word array sits inside the block so that values written by stores can be read back by loads.

A six-bit opcode selects the operation. There are five loads and three stores, and every other code is treated as no operation. Stores are written at a rising clock edge while the request input is high. Loads are combinational from the current array contents. A halfword at an odd address, or a word at an address that is not a multiple of four, raises the misaligned output. Such an access writes nothing and its load result is zero.

The block has no sequencer of its own. The only clocked state is the word array, which reset clears. Each access is a single-cycle operation.

Top module: `lsu_lane_align`

## Requirements
- R1: `eff_addr` equals `base` plus `disp` sign-extended to 32 bits, wrapping modulo 2^32.
- R2: Only opcodes 0x20, 0x21, 0x23, 0x24, 0x25 (loads) and 0x28, 0x29, 0x2B (stores) are recognised, and `op_valid` is high for exactly these. Any other opcode leaves the array unchanged, holds `load_data` and `misaligned` at 0, and keeps `op_valid` low.
- R3: Opcode 0x20 loads a byte and opcode 0x21 loads a halfword. The top bit of the loaded field fills all higher bits of `load_data`.
- R4: Opcode 0x24 loads a byte and opcode 0x25 loads a halfword. The bits of `load_data` above the field are zero. Opcode 0x23 returns the whole word.
- R5: Lanes are little-endian. The byte at address bits [1:0] = k occupies word bits 8k+7..8k. The halfword at address bit 1 = h occupies bits 16h+15..16h.
- R6: A byte store (opcode 0x28) writes `store_data[7:0]` into the addressed byte lane, and the other three bytes of the word are kept.
- R7: A halfword store (opcode 0x29) writes `store_data[15:0]` into the addressed halfword, and the other halfword is kept.
- R8: A word store (opcode 0x2B) writes all 32 bits of `store_data`.
- R9: A halfword access with address bit 0 set, or a word access with address bits [1:0] not equal to 0, sets `misaligned`. Such a store writes nothing, and such a load gives `load_data` = 0. Byte accesses are never misaligned.
- R10: A store takes effect at the rising edge of `clk` only while `req` is 1. With `req` at 0 the array is unchanged.
- R11: Reset (active-low `rst_n`) clears every word of the array to zero.
- R12: The array word is selected by `eff_addr[IDX_W+1:2]`, where IDX_W = log2(DEPTH) and DEPTH defaults to 64. Higher address bits are ignored, so addresses 256 bytes apart reach the same word at the default depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores are written on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| req | input | 1 | Access request; enables the store write |
| opcode | input | 6 | Operation code for the load or store |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| eff_addr | output | 32 | Computed byte address |
| load_data | output | 32 | Extracted and widened load result |
| misaligned | output | 1 | Access not aligned to its width |
| op_valid | output | 1 | Opcode is one of the eight accesses |

## Verification
The array is the only state, so a wrong strobe or a wrong lane shift shows up as a corrupted neighbouring byte. That corruption is visible on the next load of the same word, one clock after the faulty store. The bench therefore prefills words with distinct byte values, makes a partial store, and reads back both the whole word and each lane. A wrong extension or a wrong lane choice on the load side appears on `load_data` in the same cycle as the address, with no clock needed. An unwanted write on a misaligned, unrequested or unknown access changes a word that is read back in the next cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LD_BYTE_S = 6'h20;
    localparam logic [OPC_W-1:0] OPC_LD_HALF_S = 6'h21;
    localparam logic [OPC_W-1:0] OPC_LD_WORD   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_LD_BYTE_U = 6'h24;
    localparam logic [OPC_W-1:0] OPC_LD_HALF_U = 6'h25;
    localparam logic [OPC_W-1:0] OPC_ST_BYTE   = 6'h28;
    localparam logic [OPC_W-1:0] OPC_ST_HALF   = 6'h29;
    localparam logic [OPC_W-1:0] OPC_ST_WORD   = 6'h2B;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } access_size_e;

    typedef struct packed {
        logic         valid;
        logic         is_load;
        logic         is_store;
        logic         sign_fill;
        access_size_e size;
    } access_ctl_t;

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
    import lsu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output access_ctl_t      ctl
);

    always_comb begin
        ctl = '{valid: 1'b0, is_load: 1'b0, is_store: 1'b0,
                sign_fill: 1'b0, size: SZ_BYTE};
        unique case (opcode)
            OPC_LD_BYTE_S: ctl = '{1'b1, 1'b1, 1'b0, 1'b1, SZ_BYTE};
            OPC_LD_HALF_S: ctl = '{1'b1, 1'b1, 1'b0, 1'b1, SZ_HALF};
            OPC_LD_WORD:   ctl = '{1'b1, 1'b1, 1'b0, 1'b0, SZ_WORD};
            OPC_LD_BYTE_U: ctl = '{1'b1, 1'b1, 1'b0, 1'b0, SZ_BYTE};
            OPC_LD_HALF_U: ctl = '{1'b1, 1'b1, 1'b0, 1'b0, SZ_HALF};
            OPC_ST_BYTE:   ctl = '{1'b1, 1'b0, 1'b1, 1'b0, SZ_BYTE};
            OPC_ST_HALF:   ctl = '{1'b1, 1'b0, 1'b1, 1'b0, SZ_HALF};
            OPC_ST_WORD:   ctl = '{1'b1, 1'b0, 1'b1, 1'b0, SZ_WORD};
            default: ;
        endcase
    end

    // R2: a recognised opcode is either a load or a store, never both
    always_comb begin
        if (ctl.valid) begin
            a_r2_load_xor_store: assert (ctl.is_load ^ ctl.is_store);
        end
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  access_size_e      size,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  strobe,
    output logic [DATA_W-1:0] wdata
);

    always_comb begin
        strobe = '0;
        wdata  = src;
        unique case (size)
            SZ_BYTE: begin
                strobe       = '0;
                strobe[lane] = 1'b1;
                wdata        = {LANES{src[7:0]}};
            end
            SZ_HALF: begin
                strobe = lane[1] ? 4'b1100 : 4'b0011;
                wdata  = {(LANES/2){src[15:0]}};
            end
            SZ_WORD: begin
                strobe = '1;
                wdata  = src;
            end
            default: begin
                strobe = '0;
                wdata  = src;
            end
        endcase
    end

    // R6/R7: a byte store enables one lane, a halfword store two
    always_comb begin
        if (size == SZ_BYTE) begin
            a_r6_one_lane: assert ($countones(strobe) == 1);
        end
        if (size == SZ_HALF) begin
            a_r7_two_lanes: assert ($countones(strobe) == 2);
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        lane,
    input  access_size_e      size,
    input  logic              sign_fill,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] shifted;
    logic [7:0]        byte_v;
    logic [15:0]       half_v;

    always_comb begin
        shifted = word >> {lane, 3'b000};
        byte_v  = shifted[7:0];
        half_v  = lane[1] ? word[31:16] : word[15:0];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sign_fill & byte_v[7]}}, byte_v};
            SZ_HALF: result = {{(DATA_W-16){sign_fill & half_v[15]}}, half_v};
            SZ_WORD: result = word;
            default: result = word;
        endcase
    end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [DATA_W-1:0] store_data,
    output logic [DATA_W-1:0] eff_addr,
    output logic [DATA_W-1:0] load_data,
    output logic              misaligned,
    output logic              op_valid
);

    access_ctl_t       ctl;
    logic [IDX_W-1:0]  word_idx;
    logic [1:0]        lane;
    logic [LANES-1:0]  strobe;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] ext_data;
    logic              write_en;
    logic [DATA_W-1:0] mem_q [DEPTH];

    lsu_op_decode u_decode (
        .opcode (opcode),
        .ctl    (ctl)
    );

    always_comb begin
        eff_addr = base + {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
        word_idx = eff_addr[IDX_W+1:2];
        lane     = eff_addr[1:0];
        op_valid = ctl.valid;
        unique case (ctl.size)
            SZ_HALF: misaligned = ctl.valid & lane[0];
            SZ_WORD: misaligned = ctl.valid & (lane != 2'b00);
            default: misaligned = 1'b0;
        endcase
        write_en = req & ctl.is_store & ~misaligned;
    end

    lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
        .size   (ctl.size),
        .lane   (lane),
        .src    (store_data),
        .strobe (strobe),
        .wdata  (wdata)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .word      (mem_q[word_idx]),
        .lane      (lane),
        .size      (ctl.size),
        .sign_fill (ctl.sign_fill),
        .result    (ext_data)
    );

    always_comb begin
        load_data = (ctl.is_load && !misaligned) ? ext_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= '0;
            end
        end else if (write_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (strobe[b]) begin
                    mem_q[word_idx][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    // Snapshot of the addressed word, used to check what a cycle changed
    logic [IDX_W-1:0]  chk_idx_q;
    logic [DATA_W-1:0] chk_word_q;
    logic [DATA_W-1:0] chk_src_q;
    logic              chk_wr_q;
    logic [LANES-1:0]  chk_strb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_idx_q  <= '0;
            chk_word_q <= '0;
            chk_src_q  <= '0;
            chk_wr_q   <= 1'b0;
            chk_strb_q <= '0;
        end else begin
            chk_idx_q  <= word_idx;
            chk_word_q <= mem_q[word_idx];
            chk_src_q  <= store_data;
            chk_wr_q   <= req & ctl.is_store & ~misaligned;
            chk_strb_q <= strobe;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R6/R7/R9/R10: a lane not written keeps its old byte
        a_r10_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(chk_wr_q && chk_strb_q[g]) |->
                mem_q[chk_idx_q][8*g +: 8] == chk_word_q[8*g +: 8]);
    end

    // R8: a word store leaves exactly the source value in the word
    a_r8_word_written: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_wr_q && chk_strb_q == '1) |-> mem_q[chk_idx_q] == chk_src_q);

    // R3: signed byte load replicates bit 7 upward
    a_r3_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_LD_BYTE_S) |-> load_data[31:8] == {24{load_data[7]}});

    // R4: unsigned halfword load has a zero upper half
    a_r4_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_LD_HALF_U) |-> load_data[31:16] == 16'h0000);

    // R2: an unrecognised opcode yields no data and no flag
    a_r2_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (load_data == '0 && !misaligned));

    // R9: byte accesses never flag misalignment
    a_r9_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_LD_BYTE_S || opcode == OPC_LD_BYTE_U ||
         opcode == OPC_ST_BYTE) |-> !misaligned);

endmodule

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;
    import lsu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [5:0]  opcode = 6'h00;
    logic [31:0] base = '0;
    logic [15:0] disp = '0;
    logic [31:0] store_data = '0;
    logic [31:0] eff_addr;
    logic [31:0] load_data;
    logic        misaligned;
    logic        op_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lsu_lane_align uut (
        .clk(clk), .rst_n(rst_n), .req(req), .opcode(opcode),
        .base(base), .disp(disp), .store_data(store_data),
        .eff_addr(eff_addr), .load_data(load_data),
        .misaligned(misaligned), .op_valid(op_valid)
    );

    task automatic check(input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic do_store(input logic [5:0] op, input logic [31:0] addr,
                            input logic [31:0] val);
        @(negedge clk);
        opcode = op; base = addr; disp = 16'h0000; store_data = val; req = 1'b1;
        @(negedge clk);
        req = 1'b0; opcode = 6'h00;
    endtask

    task automatic do_load(input logic [5:0] op, input logic [31:0] addr,
                           output logic [31:0] val, output logic flag);
        @(negedge clk);
        opcode = op; base = addr; disp = 16'h0000; req = 1'b0;
        #1;
        val = load_data; flag = misaligned;
    endtask

    task automatic t_reset();
        logic [31:0] v; logic f;
        do_load(OPC_LD_WORD, 32'h0, v, f);
        check("R11 word 0 cleared", v, 32'h0);
        do_load(OPC_LD_WORD, 32'hFC, v, f);
        check("R11 last word cleared", v, 32'h0);
    endtask

    task automatic t_addr();
        @(negedge clk);
        opcode = OPC_LD_WORD; base = 32'h100; disp = 16'hFFFC; #1;
        check("R1 negative displacement", eff_addr, 32'h0000_00FC);
        base = 32'h10; disp = 16'h7FFF; #1;
        check("R1 positive displacement", eff_addr, 32'h0000_800F);
        base = 32'hFFFF_FFFF; disp = 16'h0002; #1;
        check("R1 wrap", eff_addr, 32'h0000_0001);
    endtask

    task automatic t_word_lanes();
        logic [31:0] v; logic f;
        do_store(OPC_ST_WORD, 32'h8, 32'h1122_3344);
        do_load(OPC_LD_WORD, 32'h8, v, f);
        check("R8 word readback", v, 32'h1122_3344);
        do_load(OPC_LD_BYTE_U, 32'h8, v, f);
        check("R5 lane 0", v, 32'h44);
        do_load(OPC_LD_BYTE_U, 32'h9, v, f);
        check("R5 lane 1", v, 32'h33);
        do_load(OPC_LD_BYTE_U, 32'hA, v, f);
        check("R5 lane 2", v, 32'h22);
        do_load(OPC_LD_BYTE_U, 32'hB, v, f);
        check("R5 lane 3", v, 32'h11);
        do_load(OPC_LD_HALF_U, 32'hA, v, f);
        check("R5 upper half", v, 32'h1122);
    endtask

    task automatic t_extend();
        logic [31:0] v; logic f;
        do_store(OPC_ST_WORD, 32'h10, 32'h80FF_7F01);
        do_load(OPC_LD_BYTE_S, 32'h11, v, f);
        check("R3 positive byte", v, 32'h0000_007F);
        do_load(OPC_LD_BYTE_S, 32'h12, v, f);
        check("R3 negative byte", v, 32'hFFFF_FFFF);
        do_load(OPC_LD_BYTE_S, 32'h13, v, f);
        check("R3 byte 0x80", v, 32'hFFFF_FF80);
        do_load(OPC_LD_BYTE_U, 32'h13, v, f);
        check("R4 byte 0x80", v, 32'h0000_0080);
        do_load(OPC_LD_HALF_S, 32'h10, v, f);
        check("R3 positive half", v, 32'h0000_7F01);
        do_load(OPC_LD_HALF_S, 32'h12, v, f);
        check("R3 negative half", v, 32'hFFFF_80FF);
        do_load(OPC_LD_HALF_U, 32'h12, v, f);
        check("R4 unsigned half", v, 32'h0000_80FF);
    endtask

    task automatic t_partial_store();
        logic [31:0] v; logic f;
        do_store(OPC_ST_WORD, 32'h20, 32'hAABB_CCDD);
        do_store(OPC_ST_BYTE, 32'h21, 32'h1234_5666);
        do_load(OPC_LD_WORD, 32'h20, v, f);
        check("R6 byte lane 1", v, 32'hAABB_66DD);
        do_store(OPC_ST_BYTE, 32'h23, 32'h0000_0077);
        do_load(OPC_LD_WORD, 32'h20, v, f);
        check("R6 byte lane 3", v, 32'h77BB_66DD);
        do_store(OPC_ST_HALF, 32'h22, 32'hFFFF_9876);
        do_load(OPC_LD_WORD, 32'h20, v, f);
        check("R7 upper half", v, 32'h9876_66DD);
        do_store(OPC_ST_HALF, 32'h20, 32'h0000_4321);
        do_load(OPC_LD_WORD, 32'h20, v, f);
        check("R7 lower half", v, 32'h9876_4321);
    endtask

    task automatic t_misalign();
        logic [31:0] v; logic f;
        do_store(OPC_ST_HALF, 32'h21, 32'h0000_EEEE);
        do_store(OPC_ST_WORD, 32'h22, 32'hEEEE_EEEE);
        do_load(OPC_LD_WORD, 32'h20, v, f);
        check("R9 no write when misaligned", v, 32'h9876_4321);
        do_load(OPC_LD_WORD, 32'h22, v, f);
        check("R9 word flag", {31'b0, f}, 32'h1);
        check("R9 misaligned load zero", v, 32'h0);
        do_load(OPC_LD_HALF_S, 32'h23, v, f);
        check("R9 half flag", {31'b0, f}, 32'h1);
        do_load(OPC_LD_BYTE_U, 32'h23, v, f);
        check("R9 byte never flagged", {31'b0, f}, 32'h0);
    endtask

    task automatic t_no_req();
        logic [31:0] v; logic f;
        @(negedge clk);
        opcode = OPC_ST_WORD; base = 32'h30; disp = 16'h0;
        store_data = 32'hDEAD_BEEF; req = 1'b0;
        @(negedge clk);
        do_load(OPC_LD_WORD, 32'h30, v, f);
        check("R10 no write without req", v, 32'h0);
    endtask

    task automatic t_bad_opcode();
        logic [31:0] v; logic f;
        @(negedge clk);
        opcode = 6'h2A; base = 32'h20; disp = 16'h0;
        store_data = 32'h0; req = 1'b1; #1;
        check("R2 op_valid low", {31'b0, op_valid}, 32'h0);
        check("R2 load_data zero", load_data, 32'h0);
        @(negedge clk);
        req = 1'b0;
        do_load(OPC_LD_WORD, 32'h20, v, f);
        check("R2 array unchanged", v, 32'h9876_4321);
    endtask

    task automatic t_alias();
        logic [31:0] v; logic f;
        do_store(OPC_ST_WORD, 32'h104, 32'h5A5A_0001);
        do_load(OPC_LD_WORD, 32'h4, v, f);
        check("R12 index wraps", v, 32'h5A5A_0001);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_word_lanes();
        t_extend();
        t_partial_store();
        t_misalign();
        t_no_req();
        t_bad_opcode();
        t_alias();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule